// File: doc/BRIEF.md
# ADC Control and Status Register

This block is the 16-bit control/status word of an analog-to-digital converter controller. Software writes it and reads it back over a simple full-word bus port. It holds the converter's operating fields: the interrupt enable, the start bit, the trigger source, the conversion clock divider, the operating mode and the channel. The block sends these fields straight to the converter core.

The top bit is a sticky end-of-conversion flag. The converter core sets it by pulsing one of two completion inputs, and the current operating mode decides which input counts. Software can never set the flag. To clear it, software must first read it as 1 and then write 0 to it. A DMA acknowledge also clears it; this acknowledge marks the data-register read by a transfer that the end interrupt started. The interrupt request is the flag gated by the interrupt enable.

Top module: `adc_csr`

## Requirements
- R1: After reset, `rdata_o` reads 16'h0040: only the clock-select low bit (bit 6) is 1, and `irq_o` is 0.
- R2: When `we_i` is high at a clock edge, bit 14 (interrupt enable), bit 13 (start), bits 11:8 (trigger), bits 7:6 (clock select), bits 5:3 (mode) and bits 2:0 (channel) take `wdata_i` at that edge. Bit 12 always reads 0 and ignores writes. `rdata_o` shows the current register contents combinationally.
- R3: The flag (bit 15) is set at the edge after `conv_done_i` is high if mode (bits 5:3) is 0 (single). If mode is non-zero (multi or scan), it is set instead at the edge after `seq_done_i` is high. The other completion input has no effect.
- R4: Writing 1 to bit 15 never changes the flag.
- R5: An edge where `re_i` is high, `we_i` is low and the flag is 1 arms a clear. A write with bit 15 = 0 clears the flag only if it is armed, and every such write consumes the arm. A write with bit 15 = 1 keeps the arm. When read and write happen in the same cycle, the write decides.
- R6: `dma_ack_i` high at an edge clears the flag and the arm.
- R7: If a completion event coincides with a software clear or a DMA clear, the flag ends at 1.
- R8: `irq_o` is high exactly when the flag and the interrupt enable (bit 14) are both 1.
- R9: `start_o`, `trig_sel_o`, `clk_sel_o`, `mode_o` and `chan_o` mirror their register fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Register read value |
| conv_done_i | input | 1 | Single-channel conversion complete pulse |
| seq_done_i | input | 1 | All selected channels complete pulse |
| dma_ack_i | input | 1 | DMA read of conversion data |
| irq_o | output | 1 | End-of-conversion interrupt request |
| start_o | output | 1 | Start field |
| trig_sel_o | output | 4 | Trigger select field |
| clk_sel_o | output | 2 | Clock select field |
| mode_o | output | 3 | Mode field |
| chan_o | output | 3 | Channel field |

## Verification
The bench builds the block with its default parameters, which include the set-over-clear priority. This puts the collision cases within reach: a completion pulse in the same cycle as a software clear, and a completion pulse in the same cycle as a DMA clear. In random traffic, mode is zero about half the time. Both completion inputs are therefore exercised against both mode classes, and reads, writes of 0 or 1 to the flag, and DMA acknowledges are interleaved in arbitrary order around each arm.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned FLAG_BIT  = 15;
  localparam int unsigned IE_BIT    = 14;
  localparam int unsigned START_BIT = 13;
  localparam int unsigned TRG_LSB   = 8;
  localparam int unsigned TRG_W     = 4;
  localparam int unsigned CKS_LSB   = 6;
  localparam int unsigned CKS_W     = 2;
  localparam int unsigned MODE_LSB  = 3;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned CHAN_LSB  = 0;
  localparam int unsigned CHAN_W    = 3;

  localparam logic [MODE_W-1:0] MODE_SINGLE = '0;

  typedef struct packed {
    logic              ie;
    logic              start;
    logic [TRG_W-1:0]  trg;
    logic [CKS_W-1:0]  cks;
    logic [MODE_W-1:0] mode;
    logic [CHAN_W-1:0] chan;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{ie: 1'b0, start: 1'b0, trg: '0,
                                 cks: CKS_W'(1), mode: '0, chan: '0};

  function automatic ctrl_t to_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.ie    = w[IE_BIT];
    c.start = w[START_BIT];
    c.trg   = w[TRG_LSB +: TRG_W];
    c.cks   = w[CKS_LSB +: CKS_W];
    c.mode  = w[MODE_LSB +: MODE_W];
    c.chan  = w[CHAN_LSB +: CHAN_W];
    return c;
  endfunction
endpackage

// File: rtl/adc_csr_fields.sv
module adc_csr_fields
  import adc_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctrl_t            ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (we_i) ctrl_q <= to_ctrl(wdata_i);
  end

  assign ctrl_o = ctrl_q;

  p_wr_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctrl_q == to_ctrl($past(wdata_i)));
  p_wr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));
endmodule

// File: rtl/adc_csr_flag.sv
module adc_csr_flag
  import adc_csr_pkg::*;
#(
  parameter bit SET_WINS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              wbit_i,
  input  logic              conv_done_i,
  input  logic              seq_done_i,
  input  logic              dma_ack_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ie_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic flag_q, flag_d, arm_q, arm_d;
  logic set_evt, sw_clr, clr_evt;

  // completion source depends on mode class
  assign set_evt = (mode_i == MODE_SINGLE) ? conv_done_i : seq_done_i;
  assign sw_clr  = we_i && !wbit_i && arm_q;
  assign clr_evt = sw_clr || dma_ack_i;

  generate
    if (SET_WINS) begin : g_set_prio
      always_comb flag_d = set_evt ? 1'b1 : (clr_evt ? 1'b0 : flag_q);
    end else begin : g_clr_prio
      always_comb flag_d = clr_evt ? 1'b0 : (set_evt ? 1'b1 : flag_q);
    end
  endgenerate

  always_comb begin
    arm_d = arm_q;
    if (re_i && !we_i && flag_q) arm_d = 1'b1;
    if (we_i && !wbit_i)         arm_d = 1'b0;
    if (dma_ack_i)               arm_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SET_WINS && set_evt) |=> flag_q);
  p_no_sw_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_evt));
  p_clr_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wbit_i && !arm_q && !set_evt && !dma_ack_i) |=> flag_q == $past(flag_q));
  p_dma_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_i && !set_evt) |=> !flag_q && !arm_q);
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SET_WINS && set_evt && clr_evt) |=> flag_q);
endmodule

// File: rtl/adc_csr.sv
module adc_csr
  import adc_csr_pkg::*;
#(
  parameter bit SET_WINS = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic        conv_done_i,
  input  logic        seq_done_i,
  input  logic        dma_ack_i,
  output logic        irq_o,
  output logic        start_o,
  output logic [3:0]  trig_sel_o,
  output logic [1:0]  clk_sel_o,
  output logic [2:0]  mode_o,
  output logic [2:0]  chan_o
);
  ctrl_t ctrl;
  logic  flag;

  adc_csr_fields u_fields (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl)
  );

  adc_csr_flag #(.SET_WINS(SET_WINS)) u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .re_i        (re_i),
    .wbit_i      (wdata_i[FLAG_BIT]),
    .conv_done_i (conv_done_i),
    .seq_done_i  (seq_done_i),
    .dma_ack_i   (dma_ack_i),
    .mode_i      (ctrl.mode),
    .ie_i        (ctrl.ie),
    .flag_o      (flag),
    .irq_o       (irq_o)
  );

  // bit 12 reserved, reads zero
  assign rdata_o    = {flag, ctrl.ie, ctrl.start, 1'b0, ctrl.trg, ctrl.cks, ctrl.mode, ctrl.chan};
  assign start_o    = ctrl.start;
  assign trig_sel_o = ctrl.trg;
  assign clk_sel_o  = ctrl.cks;
  assign mode_o     = ctrl.mode;
  assign chan_o     = ctrl.chan;

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[FLAG_BIT] && rdata_o[IE_BIT]));
  p_irq_raise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[FLAG_BIT] && rdata_o[IE_BIT]) |-> irq_o);
  p_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wdata_i[12] |=> !rdata_o[12]);
endmodule

// File: tb/tb_adc_csr.sv
module tb_adc_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, cd = 1'b0, sd = 1'b0, dma = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        irq, start;
  logic [3:0]  trg;
  logic [1:0]  cks;
  logic [2:0]  mode, chan;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl;
  logic        m_flag, m_arm;

  always #10 clk = ~clk;

  adc_csr dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .wdata_i(wd),
    .rdata_o(rdata), .conv_done_i(cd), .seq_done_i(sd), .dma_ack_i(dma),
    .irq_o(irq), .start_o(start), .trig_sel_o(trg), .clk_sel_o(cks),
    .mode_o(mode), .chan_o(chan)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd();
    return m_ctrl | {m_flag, 15'b0};
  endfunction

  // drive one cycle and advance the reference model
  task automatic step(input logic w, input logic r, input logic [15:0] d,
                      input logic c, input logic s, input logic a);
    logic set, clr, nflag, narm;
    set = (m_ctrl[5:3] == 3'd0) ? c : s;
    clr = a || (w && !d[15] && m_arm);
    nflag = set ? 1'b1 : (clr ? 1'b0 : m_flag);
    narm = m_arm;
    if (r && !w && m_flag) narm = 1'b1;
    if (w && !d[15]) narm = 1'b0;
    if (a) narm = 1'b0;
    we = w; re = r; wd = d; cd = c; sd = s; dma = a;
    @(negedge clk);
    we = 0; re = 0; cd = 0; sd = 0; dma = 0;
    if (w) m_ctrl = d & 16'h6FFF;
    m_flag = nflag;
    m_arm = narm;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_ctrl = 16'h0040; m_flag = 0; m_arm = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", rdata, 16'h0040);
    chk("R1 reset irq", {15'b0, irq}, 16'h0);

    step(1, 0, 16'hFFFF, 0, 0, 0);
    chk("R2 write all ones, bit12 zero", rdata, 16'h6FFF);
    chk("R9 field outputs", {start, trg, cks, mode, chan, 3'b0}, {1'b1, 4'hF, 2'h3, 3'h7, 3'h7, 3'b0});
    step(1, 0, 16'h4000, 0, 0, 0);
    chk("R2 write ie single", rdata, 16'h4000);

    step(0, 0, 0, 0, 1, 0);
    chk("R3 seq_done ignored in single", rdata, 16'h4000);
    step(0, 0, 0, 1, 0, 0);
    chk("R3 conv_done sets flag", rdata, 16'hC000);
    chk("R8 irq with ie", {15'b0, irq}, 16'h1);

    step(1, 0, 16'hC000, 0, 0, 0);
    chk("R4 write one keeps flag", rdata, 16'hC000);
    step(1, 0, 16'h4000, 0, 0, 0);
    chk("R5 write zero without read", rdata, 16'hC000);
    step(0, 1, 0, 0, 0, 0);
    step(1, 0, 16'h4000, 0, 0, 0);
    chk("R5 read then write zero clears", rdata, 16'h4000);
    chk("R8 irq low after clear", {15'b0, irq}, 16'h0);

    step(0, 0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(1, 0, 16'hC000, 0, 0, 0);
    step(1, 0, 16'h4000, 0, 0, 0);
    chk("R5 arm survives write of one", rdata, 16'h4000);
    step(0, 0, 0, 1, 0, 0);
    step(1, 0, 16'h4000, 0, 0, 0);
    chk("R5 arm consumed", rdata, 16'hC000);

    step(0, 0, 0, 0, 0, 1);
    chk("R6 dma clears flag", rdata, 16'h4000);
    step(0, 0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0, 0);
    step(1, 0, 16'h4000, 0, 0, 0);
    chk("R6 dma drops arm", rdata, 16'hC000);

    step(0, 1, 0, 0, 0, 0);
    step(1, 0, 16'h4000, 1, 0, 0);
    chk("R7 set beats sw clear", rdata, 16'hC000);
    step(0, 0, 0, 1, 0, 1);
    chk("R7 set beats dma clear", rdata, 16'hC000);

    step(0, 0, 0, 0, 0, 1);
    step(1, 0, 16'h4008, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk("R3 conv_done ignored in multi", rdata, 16'h4008);
    step(0, 0, 0, 0, 1, 0);
    chk("R3 seq_done sets in multi", rdata, 16'hC008);
    step(1, 0, 16'h8008, 0, 0, 0);
    chk("R8 irq masked by ie", {15'b0, irq}, 16'h0);
    chk("R8 flag kept", rdata, 16'h8008);

    for (int i = 0; i < 400; i++) begin
      logic w, r, c, s, a;
      logic [15:0] d;
      w = ($urandom_range(3) == 0);
      r = ($urandom_range(2) == 0);
      c = ($urandom_range(7) == 0);
      s = ($urandom_range(7) == 0);
      a = ($urandom_range(9) == 0);
      d = 16'($urandom);
      if ($urandom_range(1) == 0) d[5:3] = 3'd0;
      step(w, r, d, c, s, a);
      chk("R5 random register value", rdata, exp_rd());
      chk("R8 random irq", {15'b0, irq}, {15'b0, m_flag & m_ctrl[14]});
      chk("R9 random mode out", {13'b0, mode}, {13'b0, m_ctrl[5:3]});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule